// File: doc/BRIEF.md
# Exposure Timing and Shutter Controller

This block runs one timed camera exposure at a time in response to single-cycle command strobes: start, pause, resume, abort, manual shutter open and manual shutter close. A start first asks a readout sequencer to clear the sensor and holds that request until an acknowledge arrives. Only then does the exposure begin. The elapsed-time register is zeroed and then advances once per millisecond tick until it equals the programmed target. At that point the shutter is closed and a readout request is pulsed.

The shutter opens automatically only when the shutter option input is set. The shutter pin is active low. A one-cycle done strobe confirms every command. For a start accepted from idle, the done strobe marks the moment the exposure actually begins, not the moment the start was received. A 4-bit status word and the elapsed count can be read back at any time.

Top module: `exposure_sequencer`

## Requirements
- R1: A start received while idle raises `clrReq` on the next cycle. `clrReq` stays high until a cycle with `clrAck` high, or until an abort. Nothing else about the exposure changes while it waits.
- R2: One cycle after the cycle in which `clrAck` is seen, the following all hold: `elapsed` is 0, status bit 1 (timed exposure in progress) is 1, and `cmdDone` pulses for one cycle.
- R3: At exposure start the shutter opens only if `shutterOpt` is 1. `shutterN` is low exactly when the shutter is open, and status bit 2 is 1 exactly when it is open.
- R4: While an exposure is running, each `msTick` adds one to `elapsed`. No tick changes `elapsed` while idle, clearing, paused, or once `elapsed` equals `targetTime`.
- R5: In the cycle after `elapsed` equals `targetTime` during a running exposure, all of the following hold:
  - the shutter is closed;
  - `readoutReq` is high for exactly one cycle;
  - status bit 3 (readout pending) is set;
  - status bit 1 is cleared.
  Status bit 3 is cleared by the next start accepted from idle.
- R6: Pause during a running exposure closes the shutter, sets status bit 0 (paused) and freezes `elapsed`. Resume clears bit 0, reopens the shutter only if `shutterOpt` is 1, and counting continues from the frozen value.
- R7: Abort, in any state, does the following one cycle later: closes the shutter, returns to idle (status bits 0, 1 cleared, `clrReq` low) and pulses `idleReq` once.
- R8: Manual open and close drive the shutter in any state. When abort, pause or target-reach close the shutter in the same cycle, the closing wins.
- R9: A start received while clearing, running or paused is ignored (no `clrReq`, `elapsed` unchanged), yet `cmdDone` still pulses one cycle later.
- R10: If pause arrives in the same cycle as target-reach, the exposure completes as in R5, status bit 0 stays 0, and `cmdDone` still pulses.
- R11: Every pause, resume, abort, open or close produces a `cmdDone` pulse one cycle later, whether or not it had an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start exposure strobe |
| cmdPause | input | 1 | Pause exposure strobe |
| cmdResume | input | 1 | Resume exposure strobe |
| cmdAbort | input | 1 | Abort exposure strobe |
| cmdOpen | input | 1 | Manual shutter open strobe |
| cmdClose | input | 1 | Manual shutter close strobe |
| shutterOpt | input | 1 | Open shutter automatically during exposure |
| targetTime | input | TIME_W | Exposure length in ticks |
| msTick | input | 1 | Millisecond tick strobe |
| clrAck | input | 1 | Sensor clear finished |
| clrReq | output | 1 | Sensor clear request, held until acknowledged |
| readoutReq | output | 1 | One-cycle readout request |
| idleReq | output | 1 | One-cycle idle-mode request on abort |
| cmdDone | output | 1 | One-cycle command completion strobe |
| shutterN | output | 1 | Shutter drive, low = open |
| status | output | 4 | bit0 paused, bit1 exposing, bit2 shutter open, bit3 readout pending |
| elapsed | output | TIME_W | Elapsed ticks of current/last exposure |

## Verification
Completion of the count and a pause command can land on the same cycle. Both want to close the shutter, but only one may leave the block paused. The bench ticks the count up to the target and asserts pause in the very cycle where `elapsed` first equals `targetTime`. It then expects the readout request, a cleared paused bit, a closed shutter and a done strobe, all in the following cycle. A second collision is an abort while the clear handshake is pending, followed by a late acknowledge, which must not start an exposure.

// File: rtl/expseq_pkg.sv
package expseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_PAUSE = 2'd3
  } expState_t;

  // control -> datapath strobes, all valid for one cycle
  typedef struct packed {
    logic zeroTime;
    logic countTime;
    logic shutOpen;   // sequence-driven open
    logic shutClose;  // sequence-driven close (highest priority)
    logic manOpen;
    logic manClose;
    logic markPend;
    logic dropPend;
    logic sayDone;
    logic reqRead;
    logic reqIdle;
  } expStrobe_t;

endpackage

// File: rtl/expseq_ctrl.sv
module expseq_ctrl
  import expseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdPause,
  input  logic       cmdResume,
  input  logic       cmdAbort,
  input  logic       cmdOpen,
  input  logic       cmdClose,
  input  logic       shutterOpt,
  input  logic       msTick,
  input  logic       clrAck,
  input  logic       atTarget,
  output expStrobe_t str,
  output logic       clrReq,
  output logic       exposing,
  output logic       paused
);

  expState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    str = '0;
    if (cmdAbort) begin
      nxt           = ST_IDLE;
      str.shutClose = 1'b1;
      str.reqIdle   = 1'b1;
      str.sayDone   = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdStart) begin
            nxt          = ST_CLEAR;
            str.dropPend = 1'b1;
          end
        end
        ST_CLEAR: begin
          if (clrAck) begin
            nxt          = ST_RUN;
            str.zeroTime = 1'b1;
            str.shutOpen = shutterOpt;
            str.sayDone  = 1'b1;
          end
        end
        ST_RUN: begin
          if (atTarget) begin
            nxt           = ST_IDLE;
            str.shutClose = 1'b1;
            str.reqRead   = 1'b1;
            str.markPend  = 1'b1;
          end else if (cmdPause) begin
            nxt           = ST_PAUSE;
            str.shutClose = 1'b1;
          end else if (msTick) begin
            str.countTime = 1'b1;
          end
        end
        ST_PAUSE: begin
          if (cmdResume) begin
            nxt          = ST_RUN;
            str.shutOpen = shutterOpt;
          end
        end
        default: nxt = ST_IDLE;
      endcase
      str.manOpen  = cmdOpen;
      str.manClose = cmdClose;
      if (cmdPause || cmdResume || cmdOpen || cmdClose) str.sayDone = 1'b1;
      if (cmdStart && state != ST_IDLE) str.sayDone = 1'b1;
    end
  end

  assign clrReq   = (state == ST_CLEAR);
  assign exposing = (state == ST_RUN) || (state == ST_PAUSE);
  assign paused   = (state == ST_PAUSE);

  // R1
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !clrAck && !cmdAbort) |=> clrReq);

  // R2
  start_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exposing) |-> $past(clrAck));

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdAbort |=> (!exposing && !clrReq));

endmodule

// File: rtl/expseq_datapath.sv
module expseq_datapath
  import expseq_pkg::*;
#(
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  expStrobe_t        str,
  input  logic [TIME_W-1:0] targetTime,
  output logic [TIME_W-1:0] elapsed,
  output logic              atTarget,
  output logic              shutterOpen,
  output logic              readPend,
  output logic              cmdDone,
  output logic              readoutReq,
  output logic              idleReq
);

  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed     <= '0;
      shutterOpen <= 1'b0;
      readPend    <= 1'b0;
      cmdDone     <= 1'b0;
      readoutReq  <= 1'b0;
      idleReq     <= 1'b0;
    end else begin
      if (str.zeroTime)       elapsed <= '0;
      else if (str.countTime) elapsed <= elapsed + ONE;

      if (str.shutClose)     shutterOpen <= 1'b0;
      else if (str.shutOpen) shutterOpen <= 1'b1;
      else if (str.manClose) shutterOpen <= 1'b0;
      else if (str.manOpen)  shutterOpen <= 1'b1;

      if (str.markPend)      readPend <= 1'b1;
      else if (str.dropPend) readPend <= 1'b0;

      cmdDone    <= str.sayDone;
      readoutReq <= str.reqRead;
      idleReq    <= str.reqIdle;
    end
  end

  assign atTarget = (elapsed == targetTime);

  // R4
  elapsed_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elapsed != $past(elapsed)) |-> ((elapsed == $past(elapsed) + ONE) || (elapsed == '0)));

  // R5
  read_at_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    readoutReq |-> ($past(elapsed) == $past(targetTime)));

  // R8
  close_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.shutClose |=> !shutterOpen);

endmodule

// File: rtl/exposure_sequencer.sv
module exposure_sequencer
  import expseq_pkg::*;
#(
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdPause,
  input  logic              cmdResume,
  input  logic              cmdAbort,
  input  logic              cmdOpen,
  input  logic              cmdClose,
  input  logic              shutterOpt,
  input  logic [TIME_W-1:0] targetTime,
  input  logic              msTick,
  input  logic              clrAck,
  output logic              clrReq,
  output logic              readoutReq,
  output logic              idleReq,
  output logic              cmdDone,
  output logic              shutterN,
  output logic [3:0]        status,
  output logic [TIME_W-1:0] elapsed
);

  expStrobe_t str;
  logic atTarget, exposing, paused, shutterOpen, readPend;

  expseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdStart(cmdStart), .cmdPause(cmdPause), .cmdResume(cmdResume),
    .cmdAbort(cmdAbort), .cmdOpen(cmdOpen), .cmdClose(cmdClose),
    .shutterOpt(shutterOpt), .msTick(msTick), .clrAck(clrAck),
    .atTarget(atTarget), .str(str), .clrReq(clrReq),
    .exposing(exposing), .paused(paused)
  );

  expseq_datapath #(.TIME_W(TIME_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .targetTime(targetTime),
    .elapsed(elapsed), .atTarget(atTarget), .shutterOpen(shutterOpen),
    .readPend(readPend), .cmdDone(cmdDone), .readoutReq(readoutReq),
    .idleReq(idleReq)
  );

  assign shutterN = ~shutterOpen;
  assign status   = {readPend, shutterOpen, exposing, paused};

endmodule

// File: tb/exposure_sequencer_bench.sv
module exposure_sequencer_bench;

  localparam int TW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, cmdPause = 0, cmdResume = 0, cmdAbort = 0, cmdOpen = 0, cmdClose = 0;
  logic shutterOpt = 0, msTick = 0, clrAck = 0;
  logic [TW-1:0] targetTime = '0;
  logic clrReq, readoutReq, idleReq, cmdDone, shutterN;
  logic [3:0] status;
  logic [TW-1:0] elapsed;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  exposure_sequencer #(.TIME_W(TW)) u_exposure_sequencer (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdPause(cmdPause),
    .cmdResume(cmdResume), .cmdAbort(cmdAbort), .cmdOpen(cmdOpen),
    .cmdClose(cmdClose), .shutterOpt(shutterOpt), .targetTime(targetTime),
    .msTick(msTick), .clrAck(clrAck), .clrReq(clrReq), .readoutReq(readoutReq),
    .idleReq(idleReq), .cmdDone(cmdDone), .shutterN(shutterN),
    .status(status), .elapsed(elapsed)
  );

  // scenario table: {target[7:0], shutterOpt}
  localparam logic [8:0] SCEN [5] = '{
    {8'd3, 1'b1}, {8'd5, 1'b0}, {8'd0, 1'b1}, {8'd1, 1'b0}, {8'd7, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // 0 start,1 pause,2 resume,3 abort,4 open,5 close,6 tick,7 ack
  task automatic issue(input int which);
    case (which)
      0: cmdStart = 1;  1: cmdPause = 1;  2: cmdResume = 1; 3: cmdAbort = 1;
      4: cmdOpen = 1;   5: cmdClose = 1;  6: msTick = 1;    default: clrAck = 1;
    endcase
    @(negedge clk);
    cmdStart = 0; cmdPause = 0; cmdResume = 0; cmdAbort = 0;
    cmdOpen = 0; cmdClose = 0; msTick = 0; clrAck = 0;
  endtask

  task automatic beginExposure(input int tgt, input logic opt);
    targetTime = TW'(tgt);
    shutterOpt = opt;
    issue(0);
    chk("R1 clrReq raised", 32'(clrReq), 1);
    chk("R1 no done yet", 32'(cmdDone), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R1 clrReq held", 32'(clrReq), 1);
    chk("R1 not exposing", 32'(status[1]), 0);
    issue(7);
    chk("R2 elapsed zero", 32'(elapsed), 0);
    chk("R2 exposing bit", 32'(status[1]), 1);
    chk("R2 done at start", 32'(cmdDone), 1);
    chk("R3 shutter pin", 32'(shutterN), 32'(!opt));
    chk("R3 shutter status", 32'(status[2]), 32'(opt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("R3 reset shutter closed", 32'(shutterN), 1);
    chk("R1 reset no clrReq", 32'(clrReq), 0);
    chk("R5 reset status", 32'(status), 0);
    chk("R4 reset elapsed", 32'(elapsed), 0);

    // table-driven full exposures
    for (int k = 0; k < 5; k++) begin
      int tgt = int'(SCEN[k][8:1]);
      beginExposure(tgt, SCEN[k][0]);
      for (int i = 0; i < tgt; i++) begin
        issue(6);
        chk("R4 tick count", 32'(elapsed), 32'(i + 1));
        chk("R5 no early readout", 32'(readoutReq), 0);
      end
      @(negedge clk);
      chk("R5 readout pulse", 32'(readoutReq), 1);
      chk("R5 shutter closed", 32'(shutterN), 1);
      chk("R5 pending set", 32'(status[3]), 1);
      chk("R5 exposing cleared", 32'(status[1]), 0);
      @(negedge clk);
      chk("R5 readout single", 32'(readoutReq), 0);
      issue(6);
      chk("R4 idle tick ignored", 32'(elapsed), 32'(tgt));
    end

    // pause / resume
    beginExposure(10, 1'b1);
    chk("R5 pending cleared by start", 32'(status[3]), 0);
    repeat (3) issue(6);
    issue(1);
    chk("R6 paused bit", 32'(status[0]), 1);
    chk("R6 pause closes", 32'(shutterN), 1);
    chk("R11 pause done", 32'(cmdDone), 1);
    issue(6); issue(6);
    chk("R6 frozen count", 32'(elapsed), 3);
    issue(2);
    chk("R6 resumed", 32'(status[0]), 0);
    chk("R6 reopen", 32'(shutterN), 0);
    chk("R11 resume done", 32'(cmdDone), 1);
    issue(6);
    chk("R6 counting resumes", 32'(elapsed), 4);

    // start while running
    issue(0);
    chk("R9 busy start done", 32'(cmdDone), 1);
    chk("R9 no clear", 32'(clrReq), 0);
    chk("R9 elapsed kept", 32'(elapsed), 4);

    // manual close then open during run
    issue(5);
    chk("R8 manual close", 32'(shutterN), 1);
    chk("R11 close done", 32'(cmdDone), 1);
    issue(4);
    chk("R8 manual open", 32'(status[2]), 1);

    // abort
    issue(3);
    chk("R7 idle request", 32'(idleReq), 1);
    chk("R7 shutter closed", 32'(shutterN), 1);
    chk("R7 not exposing", 32'(status[1]), 0);
    chk("R11 abort done", 32'(cmdDone), 1);
    @(negedge clk);
    chk("R7 idle pulse single", 32'(idleReq), 0);

    // manual shutter while idle
    issue(4);
    chk("R8 idle open", 32'(shutterN), 0);
    issue(5);
    chk("R8 idle close", 32'(shutterN), 1);

    // pause and open colliding: pause closing wins
    beginExposure(9, 1'b0);
    cmdOpen = 1;
    issue(1);
    chk("R8 pause beats open", 32'(shutterN), 1);

    // abort during clear wait, then late ack
    issue(3);
    targetTime = TW'(4);
    issue(0);
    chk("R1 clear pending", 32'(clrReq), 1);
    issue(3);
    chk("R7 abort drops clear", 32'(clrReq), 0);
    issue(7);
    chk("R1 late ack ignored", 32'(status[1]), 0);
    chk("R1 late ack no done", 32'(cmdDone), 0);

    // pause in the cycle the target is reached
    beginExposure(2, 1'b1);
    issue(6); issue(6);
    chk("R10 at target", 32'(elapsed), 2);
    issue(1);
    chk("R10 readout wins", 32'(readoutReq), 1);
    chk("R10 not paused", 32'(status[0]), 0);
    chk("R10 pause done", 32'(cmdDone), 1);
    chk("R10 shutter closed", 32'(shutterN), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule